// File: doc/BRIEF.md
# GPIO Port Register File

This block is the software-visible register store of a 16-pin general-purpose I/O port. It sits on a simple 32-bit word bus with single-cycle requests and holds every per-pin configuration word: direction mode, output driver type, drive speed, pull selection, a lock word, two alternate-function words and an analog-control word. It also holds the output data latch. The pin-level logic lives in a separate resolution block. This block feeds that block the mode, driver type, pull and output data vectors, and returns its input data vector when software reads the input word.

Software can change the output latch in three ways: a direct write, a combined set/clear word in which a set bit beats a clear bit for the same pin, or a clear-only word. The set/clear and clear-only words are write-only and read as zero. Any write that can change a pin's resolved level (mode, driver type, pull, or any of the three output-latch paths) raises a one-cycle refresh strobe toward the resolution block. The lock, speed, alternate-function and analog words are only stored and read back. The port width parameter must satisfy 2 × pins ≤ 32.

Top module: `gpio_port_regs`

## Requirements
- R1: In reset and after it, the mode, speed and pull words hold their parameter reset values, every other word and the output latch hold zero, rdata is zero and upd_o is low.
- R2: The mode (word 0x00), speed (0x08), pull (0x0C), alternate-low (0x20) and alternate-high (0x24) words store all 32 written bits and read them back unchanged.
- R3: The driver-type (0x04), output-data (0x14), lock (0x1C) and analog (0x2C) words keep only bits 15:0 of a write; bits 31:16 read back as zero.
- R4: A write to the set/clear word (0x18) sets output latch bit i when wdata bit i is 1 and clears it when wdata bit 16+i is 1; when both are 1 the bit ends set.
- R5: A write to the clear-only word (0x28) clears output latch bit i for each 1 in wdata bit i; wdata bits 31:16 have no effect.
- R6: Reads of 0x18 and 0x28 return zero; a write to the input word (0x10) changes nothing, and a read of it returns idata_i as sampled in the request cycle.
- R7: An offset above 0x2C inside the 0x400 window, or one with addr[1:0] not zero, reads as zero and a write to it changes no register.
- R8: Read data appears on rdata in the cycle after the read request and rdata is zero in every cycle that does not follow a read request.
- R9: upd_o is high for exactly the cycle after each write to 0x00, 0x04, 0x0C, 0x14, 0x18 or 0x28, and low after any other request or idle cycle.
- R10: mode_o, otype_o, pull_o and odata_o always show the current stored mode, driver-type, pull and output-latch values; a mode field value of 01 is output, and a pull field value of 01 is pull-up and 10 pull-down, two bits per pin at bits 2i+1:2i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Bus request, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 10 | Byte address within the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after the request |
| mode_o | output | 32 | Two-bit direction mode per pin |
| otype_o | output | 16 | Driver type per pin |
| pull_o | output | 32 | Two-bit pull selection per pin |
| odata_o | output | 16 | Output data latch |
| idata_i | input | 16 | Resolved pin levels from the resolution block |
| upd_o | output | 1 | One-cycle refresh strobe toward the resolution block |

## Verification
The embedded assertions watch, on every cycle, that rdata is zero after any non-read cycle, that the strobe only follows a write, that no output vector moves without a write, that a set bit always lands in the latch after a set/clear write and that a clear-only write always leaves its bits low. Stored widths, the exact value read back from each word, the zero readback of the write-only words, the sampling instant of the input word and the handling of misaligned and unmapped offsets can only be shown by the bench's scenarios, which compare every output against a behavioural model in every cycle through directed and random access streams.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    // Word selector; the numeric value is the word index (byte offset / 4).
    typedef enum logic [3:0] {
        SEL_MODE   = 4'd0,
        SEL_OTYPE  = 4'd1,
        SEL_SPEED  = 4'd2,
        SEL_PULL   = 4'd3,
        SEL_IDATA  = 4'd4,
        SEL_ODATA  = 4'd5,
        SEL_SETCLR = 4'd6,
        SEL_LOCK   = 4'd7,
        SEL_AFLO   = 4'd8,
        SEL_AFHI   = 4'd9,
        SEL_CLR    = 4'd10,
        SEL_ANALOG = 4'd11,
        SEL_NONE   = 4'd15
    } reg_sel_e;

    localparam int unsigned LAST_WORD = 11;

    // Words whose write can change a resolved pin level.
    function automatic logic sel_touches_pins(input reg_sel_e s);
        return (s == SEL_MODE) || (s == SEL_OTYPE) || (s == SEL_PULL) ||
               (s == SEL_ODATA) || (s == SEL_SETCLR) || (s == SEL_CLR);
    endfunction

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
    import gpio_port_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic [AW-1:0] addr,
    output reg_sel_e      sel
);
    localparam int WW = AW - 2;

    logic [WW-1:0] word;

    always_comb begin
        word = addr[AW-1:2];
        if (addr[1:0] != 2'b00 || word > WW'(LAST_WORD)) begin
            sel = SEL_NONE;
        end else begin
            sel = reg_sel_e'(word[3:0]);
        end
    end
endmodule

// File: rtl/gpio_odata_next.sv
module gpio_odata_next
    import gpio_port_pkg::*;
#(
    parameter int NPINS = 16,
    parameter int DW    = 32
) (
    input  logic [NPINS-1:0] odata_q,
    input  logic             wr,
    input  reg_sel_e         sel,
    input  logic [DW-1:0]    wdata,
    output logic [NPINS-1:0] odata_d
);
    logic [NPINS-1:0] set_m;
    logic [NPINS-1:0] clr_m;

    always_comb begin
        set_m   = '0;
        clr_m   = '0;
        odata_d = odata_q;
        if (wr) begin
            unique case (sel)
                SEL_ODATA:  odata_d = wdata[NPINS-1:0];
                SEL_SETCLR: begin
                    set_m = wdata[NPINS-1:0];
                    clr_m = wdata[2*NPINS-1:NPINS];
                end
                SEL_CLR:    clr_m = wdata[NPINS-1:0];
                default:    ;
            endcase
            // Set is applied after clear, so it wins on overlap.
            if (sel == SEL_SETCLR || sel == SEL_CLR) begin
                odata_d = (odata_q & ~clr_m) | set_m;
            end
        end
    end
endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
    import gpio_port_pkg::*;
#(
    parameter int NPINS = 16,
    parameter int DW    = 32
) (
    input  reg_sel_e           sel,
    input  logic [2*NPINS-1:0] mode,
    input  logic [NPINS-1:0]   otype,
    input  logic [2*NPINS-1:0] speed,
    input  logic [2*NPINS-1:0] pull,
    input  logic [NPINS-1:0]   idata,
    input  logic [NPINS-1:0]   odata,
    input  logic [NPINS-1:0]   lock,
    input  logic [DW-1:0]      aflo,
    input  logic [DW-1:0]      afhi,
    input  logic [NPINS-1:0]   analog,
    output logic [DW-1:0]      rval
);
    always_comb begin
        rval = '0;
        unique case (sel)
            SEL_MODE:   rval[2*NPINS-1:0] = mode;
            SEL_OTYPE:  rval[NPINS-1:0]   = otype;
            SEL_SPEED:  rval[2*NPINS-1:0] = speed;
            SEL_PULL:   rval[2*NPINS-1:0] = pull;
            SEL_IDATA:  rval[NPINS-1:0]   = idata;
            SEL_ODATA:  rval[NPINS-1:0]   = odata;
            SEL_LOCK:   rval[NPINS-1:0]   = lock;
            SEL_AFLO:   rval              = aflo;
            SEL_AFHI:   rval              = afhi;
            SEL_ANALOG: rval[NPINS-1:0]   = analog;
            default:    rval              = '0;
        endcase
    end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int           NPINS     = 16,
    parameter int           AW        = 10,
    parameter logic [31:0]  MODE_RST  = 32'h0000_0000,
    parameter logic [31:0]  SPEED_RST = 32'h0000_0000,
    parameter logic [31:0]  PULL_RST  = 32'h0000_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic               we,
    input  logic [AW-1:0]      addr,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    output logic [2*NPINS-1:0] mode_o,
    output logic [NPINS-1:0]   otype_o,
    output logic [2*NPINS-1:0] pull_o,
    output logic [NPINS-1:0]   odata_o,
    input  logic [NPINS-1:0]   idata_i,
    output logic               upd_o
);
    localparam int DW = 32;
    localparam int FW = 2 * NPINS;

    typedef struct packed {
        logic [FW-1:0]    mode;
        logic [NPINS-1:0] otype;
        logic [FW-1:0]    speed;
        logic [FW-1:0]    pull;
        logic [NPINS-1:0] odata;
        logic [NPINS-1:0] lock;
        logic [DW-1:0]    aflo;
        logic [DW-1:0]    afhi;
        logic [NPINS-1:0] analog;
        logic [DW-1:0]    rdata;
        logic             upd;
    } state_t;

    state_t   st_d, st_q;
    reg_sel_e sel;
    logic     wr_en, rd_en;
    logic [NPINS-1:0] odata_nx;
    logic [DW-1:0]    rval;

    assign wr_en = req && we;
    assign rd_en = req && !we;

    gpio_addr_dec #(.AW(AW)) u_dec (
        .addr (addr),
        .sel  (sel)
    );

    gpio_odata_next #(.NPINS(NPINS), .DW(DW)) u_odata (
        .odata_q (st_q.odata),
        .wr      (wr_en),
        .sel     (sel),
        .wdata   (wdata),
        .odata_d (odata_nx)
    );

    gpio_rd_mux #(.NPINS(NPINS), .DW(DW)) u_rmux (
        .sel    (sel),
        .mode   (st_q.mode),
        .otype  (st_q.otype),
        .speed  (st_q.speed),
        .pull   (st_q.pull),
        .idata  (idata_i),
        .odata  (st_q.odata),
        .lock   (st_q.lock),
        .aflo   (st_q.aflo),
        .afhi   (st_q.afhi),
        .analog (st_q.analog),
        .rval   (rval)
    );

    always_comb begin
        st_d       = st_q;
        st_d.odata = odata_nx;
        st_d.rdata = rd_en ? rval : '0;
        st_d.upd   = wr_en && sel_touches_pins(sel);
        if (wr_en) begin
            unique case (sel)
                SEL_MODE:   st_d.mode   = wdata[FW-1:0];
                SEL_OTYPE:  st_d.otype  = wdata[NPINS-1:0];
                SEL_SPEED:  st_d.speed  = wdata[FW-1:0];
                SEL_PULL:   st_d.pull   = wdata[FW-1:0];
                SEL_LOCK:   st_d.lock   = wdata[NPINS-1:0];
                SEL_AFLO:   st_d.aflo   = wdata;
                SEL_AFHI:   st_d.afhi   = wdata;
                SEL_ANALOG: st_d.analog = wdata[NPINS-1:0];
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.mode  <= MODE_RST[FW-1:0];
            st_q.speed <= SPEED_RST[FW-1:0];
            st_q.pull  <= PULL_RST[FW-1:0];
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata   = st_q.rdata;
    assign mode_o  = st_q.mode;
    assign otype_o = st_q.otype;
    assign pull_o  = st_q.pull;
    assign odata_o = st_q.odata;
    assign upd_o   = st_q.upd;

    // Read data only follows a read request.
    assert_rdata_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req && !we) |-> rdata == '0);

    // Refresh strobe only follows a write.
    assert_upd_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |-> $past(req && we));

    // Pin-facing vectors hold steady without a write.
    assert_hold_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req && we) |-> ($stable(odata_o) && $stable(mode_o) &&
                               $stable(pull_o) && $stable(otype_o)));

    // Set bits always land, even when the matching clear bit is also 1.
    assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req && we && addr == AW'(24)) |->
            ((odata_o & $past(wdata[NPINS-1:0])) == $past(wdata[NPINS-1:0])));

    // Clear-only word always leaves its selected bits low.
    assert_clear_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req && we && addr == AW'(40)) |->
            ((odata_o & $past(wdata[NPINS-1:0])) == '0));
endmodule

// File: tb/gpio_port_regs_test.sv
`timescale 1ns/1ps
module gpio_port_regs_test;
    localparam logic [31:0] P_MODE  = 32'hABFF_0041;
    localparam logic [31:0] P_SPEED = 32'h0C00_00F0;
    localparam logic [31:0] P_PULL  = 32'h6410_0102;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [9:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] mode_o;
    logic [15:0] otype_o;
    logic [31:0] pull_o;
    logic [15:0] odata_o;
    logic [15:0] idata_i = '0;
    logic        upd_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Behavioural reference state
    logic [31:0] m_mode, m_otype, m_speed, m_pull, m_odata, m_lock, m_aflo, m_afhi, m_analog;
    logic [31:0] e_rdata;
    logic        e_upd;

    always #10 clk = ~clk;

    gpio_port_regs #(.MODE_RST(P_MODE), .SPEED_RST(P_SPEED), .PULL_RST(P_PULL)) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
        .rdata(rdata), .mode_o(mode_o), .otype_o(otype_o), .pull_o(pull_o),
        .odata_o(odata_o), .idata_i(idata_i), .upd_o(upd_o)
    );

    task automatic model_reset();
        m_mode = P_MODE; m_speed = P_SPEED; m_pull = P_PULL;
        m_otype = 0; m_odata = 0; m_lock = 0; m_aflo = 0; m_afhi = 0; m_analog = 0;
        e_rdata = 0; e_upd = 0;
    endtask

    function automatic int word_of(input logic [9:0] a);
        if (a[1:0] != 2'b00 || (a >> 2) > 11) return -1;
        return int'(a >> 2);
    endfunction

    function automatic logic [31:0] ref_read(input logic [9:0] a, input logic [15:0] pins);
        case (word_of(a))
            0: return m_mode;   1: return m_otype;  2: return m_speed;
            3: return m_pull;   4: return {16'h0, pins};
            5: return m_odata;  7: return m_lock;   8: return m_aflo;
            9: return m_afhi;   11: return m_analog;
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_edge(input logic r, input logic w, input logic [9:0] a,
                              input logic [31:0] d, input logic [15:0] pins);
        int k;
        k = word_of(a);
        e_rdata = (r && !w) ? ref_read(a, pins) : 32'h0;
        e_upd   = r && w && (k == 0 || k == 1 || k == 3 || k == 5 || k == 6 || k == 10);
        if (r && w) begin
            case (k)
                0: m_mode = d;
                1: m_otype = d & 32'hFFFF;
                2: m_speed = d;
                3: m_pull = d;
                5: m_odata = d & 32'hFFFF;
                6: m_odata = ((m_odata & ~(d >> 16)) | d) & 32'hFFFF;
                7: m_lock = d & 32'hFFFF;
                8: m_aflo = d;
                9: m_afhi = d;
                10: m_odata = m_odata & ~(d & 32'hFFFF);
                11: m_analog = d & 32'hFFFF;
                default: ;
            endcase
        end
    endtask

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        chk(tag, "rdata (R8)", rdata, e_rdata);
        chk(tag, "upd_o (R9)", {31'h0, upd_o}, {31'h0, e_upd});
        chk(tag, "mode_o (R10)", mode_o, m_mode);
        chk(tag, "otype_o (R10)", {16'h0, otype_o}, m_otype);
        chk(tag, "pull_o (R10)", pull_o, m_pull);
        chk(tag, "odata_o (R10)", {16'h0, odata_o}, m_odata);
    endtask

    task automatic step(input logic r, input logic w, input logic [9:0] a,
                        input logic [31:0] d, input logic [15:0] pins, input string tag);
        @(negedge clk);
        req = r; we = w; addr = a; wdata = d; idata_i = pins;
        @(posedge clk);
        model_edge(r, w, a, d, pins);
        #5;
        compare_all(tag);
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d, input string tag);
        step(1'b1, 1'b1, a, d, idata_i, tag);
    endtask

    task automatic rd(input logic [9:0] a, input string tag);
        step(1'b1, 1'b0, a, 32'h0, idata_i, tag);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 1'b0, 10'h0, 32'h0, idata_i, tag);
    endtask

    initial begin
        #(20.0 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #5;
        compare_all("R1 in reset");
        @(negedge clk);
        rst_n = 1'b1;
        idle("R1 after reset");
        for (int i = 0; i < 12; i++) rd(10'(i * 4), "R1 reset readback");

        // Full-width words
        wr(10'h00, 32'h5A5A_C3C3, "R2 mode");
        wr(10'h08, 32'hFFFF_FFFF, "R2 speed");
        wr(10'h0C, 32'h9999_6666, "R2 pull");
        wr(10'h20, 32'hDEAD_BEEF, "R2 af low");
        wr(10'h24, 32'h0123_4567, "R2 af high");
        rd(10'h00, "R2"); rd(10'h08, "R2"); rd(10'h0C, "R2");
        rd(10'h20, "R2"); rd(10'h24, "R2");

        // Half-width words
        wr(10'h04, 32'hFFFF_8001, "R3 otype");
        wr(10'h14, 32'h1234_A5A5, "R3 odata");
        wr(10'h1C, 32'hFFFF_FFFF, "R3 lock");
        wr(10'h2C, 32'hABCD_00F1, "R3 analog");
        rd(10'h04, "R3"); rd(10'h14, "R3"); rd(10'h1C, "R3"); rd(10'h2C, "R3");

        // Set/clear word with overlap: set 0x0F0F, clear 0x00FF
        wr(10'h14, 32'h0000_00F0, "R4 preset");
        wr(10'h18, 32'h00FF_0F0F, "R4 set wins");
        rd(10'h14, "R4 readback");
        chk("R4", "odata after set/clear", {16'h0, odata_o}, 32'h0000_0F0F);
        wr(10'h18, 32'hFFFF_0000, "R4 clear all");

        // Clear-only word, upper half ignored
        wr(10'h14, 32'h0000_FFFF, "R5 preset");
        wr(10'h28, 32'hFFFF_0003, "R5 clear only");
        chk("R5", "odata after clear-only", {16'h0, odata_o}, 32'h0000_FFFC);

        // Write-only words read zero; input word
        rd(10'h18, "R6 set/clear reads zero");
        rd(10'h28, "R6 clear-only reads zero");
        step(1'b1, 1'b1, 10'h10, 32'hFFFF_FFFF, 16'h5A5A, "R6 input write ignored");
        step(1'b1, 1'b0, 10'h10, 32'h0, 16'h5A5A, "R6 input read");
        step(1'b1, 1'b0, 10'h10, 32'h0, 16'hC001, "R6 input sampled");
        chk("R6", "input word read", rdata, 32'h0000_C001);

        // Unmapped and misaligned
        wr(10'h30, 32'hFFFF_FFFF, "R7 unmapped write");
        wr(10'h3FC, 32'hFFFF_FFFF, "R7 top of window write");
        wr(10'h15, 32'h0000_0000, "R7 misaligned write");
        wr(10'h01, 32'h0000_0000, "R7 misaligned mode write");
        rd(10'h30, "R7 unmapped read");
        rd(10'h16, "R7 misaligned read");
        rd(10'h14, "R7 odata untouched");

        // Strobe and latency around idle cycles
        idle("R8 idle zero");
        wr(10'h08, 32'h0, "R9 speed write no strobe");
        wr(10'h0C, 32'h0000_0005, "R9 pull write strobe");
        idle("R9 strobe drops");

        // Random stream
        for (int n = 0; n < 2000; n++) begin
            logic [9:0] a;
            a = 10'((($urandom % 14) * 4));
            if ($urandom % 8 == 0) a = a + 10'($urandom_range(1, 3));
            if ($urandom % 32 == 0) a = 10'h3FC;
            step(1'($urandom % 4 != 0), 1'($urandom % 2), a, $urandom,
                 16'($urandom), "R4 R5 R10 random");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule